// File: doc/BRIEF.md
# RV32I Main Control Decoder

This block is the first stage of instruction decode in a single-cycle RV32I core. It takes the 7-bit major opcode, which is the low seven bits of every instruction word, and produces the control bundle that steers the datapath. The bundle covers:

- register-file write enable;
- data-memory read and write enables;
- a three-way select for the ALU's second operand;
- a selector for the writeback source;
- three separate next-PC flags: conditional branch, direct jump and register-indirect jump;
- a coarse ALU class that a later ALU-control stage refines using the function fields.

The decoder is purely combinational. Its outputs follow the opcode within the same cycle, with no state and no clock.

Any opcode outside the nine RV32I base groups is treated as illegal. For such an opcode every enable that can change architectural state is held low, and a dedicated illegal flag is raised for the core's fault path.

Top module: `rv_main_decoder`

## Requirements
- R1: Opcode 0010011 (immediate arithmetic) gives reg_wr=1, op2_sel=1 (I-immediate), wb_sel=0 (ALU result), alu_class=3 (I-function decode), and no memory access or PC flag.
- R2: Opcode 0100011 (store) gives mem_wr=1, reg_wr=0, mem_rd=0, op2_sel=1, alu_class=0 (address add).
- R3: Opcode 0000011 (load) gives mem_rd=1, reg_wr=1, wb_sel=1 (memory data), op2_sel=1, alu_class=0.
- R4: Opcode 0110011 (register-register) gives reg_wr=1, op2_sel=0 (rs2), wb_sel=0, alu_class=2 (R-function decode).
- R5: Opcode 1100011 (branch) gives is_branch=1, op2_sel=2 (B-immediate), alu_class=1 (compare), and reg_wr=mem_rd=mem_wr=0.
- R6: Opcode 1101111 gives is_jal=1; opcode 1100111 gives is_jalr=1 with op2_sel=1. Both give reg_wr=1 and wb_sel=2 (PC+4 link).
- R7: Opcode 0110111 gives reg_wr=1 with wb_sel=3 (U-immediate). Opcode 0010111 gives reg_wr=1 with wb_sel=4 (PC plus U-immediate).
- R8: Every other opcode, 1111111 included, gives illegal=1 with every other output 0. The illegal flag is 0 for the nine listed opcodes.
- R9: At most one of is_branch, is_jal and is_jalr is high, and mem_rd and mem_wr are never high together, for any opcode.
- R10: Fields not named for an opcode are 0: op2_sel=0 for jal, lui and auipc; wb_sel=0 for store and branch; alu_class=0 for every group except R1, R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Major opcode, instruction bits 6..0 |
| reg_wr | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_wr | output | 1 | Data memory write enable |
| op2_sel | output | 2 | ALU second operand: 0 rs2, 1 I-immediate, 2 B-immediate |
| wb_sel | output | 3 | Writeback: 0 ALU, 1 memory, 2 PC+4, 3 U-immediate, 4 PC+U-immediate |
| is_branch | output | 1 | Conditional branch flag for next-PC selection |
| is_jal | output | 1 | Direct jump flag |
| is_jalr | output | 1 | Register-indirect jump flag |
| alu_class | output | 2 | Coarse ALU class: 0 add, 1 compare, 2 R-function, 3 I-function |
| illegal | output | 1 | Unrecognised opcode |

## Verification
The assertions evaluate on every opcode change and cover the structural invariants. They check that an illegal opcode leaves the state-changing enables low, that the next-PC flags and the memory enables are mutually exclusive, that a store never writes a register, that a load always returns memory data to a register, and that a branch writes nothing. Only the bench's scenarios can show the exact value of each field for each opcode, such as the I-class code on immediate arithmetic, the writeback choices for the link and U-type groups, and the zeroing of unused fields. The bench therefore sweeps all 128 opcodes in both ascending and descending order, along with near-miss patterns one bit away from legal codes.

// File: rtl/rv_ctl_pkg.sv
package rv_ctl_pkg;

  localparam int OPC_W   = 7;
  localparam int N_KINDS = 9;
  localparam int KIND_W  = $clog2(N_KINDS + 1);

  typedef enum logic [1:0] {
    OP2_RS2  = 2'd0,
    OP2_IIMM = 2'd1,
    OP2_BIMM = 2'd2
  } op2_sel_e;

  typedef enum logic [2:0] {
    WB_ALU    = 3'd0,
    WB_MEM    = 3'd1,
    WB_LINK   = 3'd2,
    WB_UIMM   = 3'd3,
    WB_PCUIMM = 3'd4
  } wb_sel_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'd0,
    ALU_CMP   = 2'd1,
    ALU_RFUNC = 2'd2,
    ALU_IFUNC = 2'd3
  } alu_cls_e;

  // Kind index order matches KIND_OPC below; K_BAD is the fallthrough.
  typedef enum logic [KIND_W-1:0] {
    K_REG   = 4'd0,
    K_IMM   = 4'd1,
    K_LOAD  = 4'd2,
    K_STORE = 4'd3,
    K_BR    = 4'd4,
    K_JAL   = 4'd5,
    K_JALR  = 4'd6,
    K_LUI   = 4'd7,
    K_AUIPC = 4'd8,
    K_BAD   = 4'd9
  } kind_e;

  localparam logic [OPC_W-1:0] KIND_OPC [N_KINDS] = '{
    7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011,
    7'b1101111, 7'b1100111, 7'b0110111, 7'b0010111
  };

  typedef struct packed {
    logic     reg_wr;
    logic     mem_rd;
    logic     mem_wr;
    op2_sel_e op2_sel;
    wb_sel_e  wb_sel;
    logic     is_branch;
    logic     is_jal;
    logic     is_jalr;
    alu_cls_e alu_class;
    logic     illegal;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{
    reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, op2_sel: OP2_RS2,
    wb_sel: WB_ALU, is_branch: 1'b0, is_jal: 1'b0, is_jalr: 1'b0,
    alu_class: ALU_ADD, illegal: 1'b0
  };

endpackage

// File: rtl/rvc_opcode_class.sv
module rvc_opcode_class
  import rv_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output kind_e            kind
);

  logic [N_KINDS-1:0] hit;

  // One exact comparator per legal opcode group.
  for (genvar g = 0; g < N_KINDS; g++) begin : g_match
    assign hit[g] = (opcode == KIND_OPC[g]);
  end

  always_comb begin
    kind = K_BAD;
    for (int i = N_KINDS - 1; i >= 0; i--) begin
      if (hit[i]) kind = kind_e'(i[KIND_W-1:0]);
    end
  end

endmodule

// File: rtl/rvc_ctl_table.sv
module rvc_ctl_table
  import rv_ctl_pkg::*;
(
  input  kind_e kind,
  output ctl_t  ctl
);

  always_comb begin
    ctl = CTL_IDLE;
    unique case (kind)
      K_REG: begin
        ctl.reg_wr    = 1'b1;
        ctl.alu_class = ALU_RFUNC;
      end
      K_IMM: begin
        ctl.reg_wr    = 1'b1;
        ctl.op2_sel   = OP2_IIMM;
        ctl.alu_class = ALU_IFUNC;
      end
      K_LOAD: begin
        ctl.reg_wr  = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.op2_sel = OP2_IIMM;
        ctl.wb_sel  = WB_MEM;
      end
      K_STORE: begin
        ctl.mem_wr  = 1'b1;
        ctl.op2_sel = OP2_IIMM;
      end
      K_BR: begin
        ctl.is_branch = 1'b1;
        ctl.op2_sel   = OP2_BIMM;
        ctl.alu_class = ALU_CMP;
      end
      K_JAL: begin
        ctl.reg_wr = 1'b1;
        ctl.is_jal = 1'b1;
        ctl.wb_sel = WB_LINK;
      end
      K_JALR: begin
        ctl.reg_wr  = 1'b1;
        ctl.is_jalr = 1'b1;
        ctl.op2_sel = OP2_IIMM;
        ctl.wb_sel  = WB_LINK;
      end
      K_LUI: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_sel = WB_UIMM;
      end
      K_AUIPC: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_sel = WB_PCUIMM;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rv_main_decoder.sv
module rv_main_decoder
  import rv_ctl_pkg::*;
(
  input  logic [6:0] opcode,
  output logic       reg_wr,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [1:0] op2_sel,
  output logic [2:0] wb_sel,
  output logic       is_branch,
  output logic       is_jal,
  output logic       is_jalr,
  output logic [1:0] alu_class,
  output logic       illegal
);

  kind_e kind;
  ctl_t  ctl;

  rvc_opcode_class u_class (
    .opcode (opcode),
    .kind   (kind)
  );

  rvc_ctl_table u_table (
    .kind (kind),
    .ctl  (ctl)
  );

  assign reg_wr    = ctl.reg_wr;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign op2_sel   = ctl.op2_sel;
  assign wb_sel    = ctl.wb_sel;
  assign is_branch = ctl.is_branch;
  assign is_jal    = ctl.is_jal;
  assign is_jalr   = ctl.is_jalr;
  assign alu_class = ctl.alu_class;
  assign illegal   = ctl.illegal;

endmodule

// File: rtl/rv_main_decoder_chk.sv
module rv_main_decoder_chk (
  input logic [6:0] opcode,
  input logic       reg_wr,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [2:0] wb_sel,
  input logic       is_branch,
  input logic       is_jal,
  input logic       is_jalr,
  input logic       illegal
);

  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_illegal_quiet_R8: assert (!illegal || (!reg_wr && !mem_rd && !mem_wr
                                        && !is_branch && !is_jal && !is_jalr))
        else $error("R8 illegal opcode with enable set");
      assert_pc_flags_onehot_R9: assert ($onehot0({is_branch, is_jal, is_jalr}))
        else $error("R9 more than one next-PC flag");
      assert_mem_exclusive_R9: assert (!(mem_rd && mem_wr))
        else $error("R9 memory read and write together");
      assert_store_no_regwr_R2: assert (!mem_wr || !reg_wr)
        else $error("R2 store writes register");
      assert_load_writeback_R3: assert (!mem_rd || (reg_wr && wb_sel == 3'd1))
        else $error("R3 load without memory writeback");
      assert_branch_no_write_R5: assert (!is_branch || (!reg_wr && !mem_wr))
        else $error("R5 branch writes state");
    end
  end

endmodule

bind rv_main_decoder rv_main_decoder_chk u_chk (
  .opcode    (opcode),
  .reg_wr    (reg_wr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .wb_sel    (wb_sel),
  .is_branch (is_branch),
  .is_jal    (is_jal),
  .is_jalr   (is_jalr),
  .illegal   (illegal)
);

// File: tb/rv_main_decoder_test.sv
`timescale 1ns/1ps
module rv_main_decoder_test;

  // {reg_wr,mem_rd,mem_wr,op2[1:0],wb[2:0],br,jal,jalr,alu[1:0],ill}
  typedef logic [14:0] exp_t;

  typedef struct {
    logic [6:0] opc;
    exp_t       exp;
  } item_t;

  logic clk;
  logic [6:0] opcode;
  logic reg_wr, mem_rd, mem_wr, is_branch, is_jal, is_jalr, illegal;
  logic [1:0] op2_sel, alu_class;
  logic [2:0] wb_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  item_t sb[$];

  rv_main_decoder uut (
    .opcode(opcode), .reg_wr(reg_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .op2_sel(op2_sel), .wb_sel(wb_sel), .is_branch(is_branch),
    .is_jal(is_jal), .is_jalr(is_jalr), .alu_class(alu_class),
    .illegal(illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t pack(bit rw, bit mr, bit mw, int o2, int wb,
                                bit br, bit j, bit jr, int alu, bit ill);
    return {rw, mr, mw, o2[1:0], wb[2:0], br, j, jr, alu[1:0], ill};
  endfunction

  function automatic exp_t model(logic [6:0] op);
    case (op)
      7'b0010011: return pack(1,0,0,1,0,0,0,0,3,0); // R1
      7'b0100011: return pack(0,0,1,1,0,0,0,0,0,0); // R2
      7'b0000011: return pack(1,1,0,1,1,0,0,0,0,0); // R3
      7'b0110011: return pack(1,0,0,0,0,0,0,0,2,0); // R4
      7'b1100011: return pack(0,0,0,2,0,1,0,0,1,0); // R5
      7'b1101111: return pack(1,0,0,0,2,0,1,0,0,0); // R6
      7'b1100111: return pack(1,0,0,1,2,0,0,1,0,0); // R6
      7'b0110111: return pack(1,0,0,0,3,0,0,0,0,0); // R7
      7'b0010111: return pack(1,0,0,0,4,0,0,0,0,0); // R7
      default:    return pack(0,0,0,0,0,0,0,0,0,1); // R8
    endcase
  endfunction

  function automatic string tag(logic [6:0] op);
    case (op)
      7'b0010011: return "R1";
      7'b0100011: return "R2";
      7'b0000011: return "R3";
      7'b0110011: return "R4";
      7'b1100011: return "R5";
      7'b1101111, 7'b1100111: return "R6";
      7'b0110111, 7'b0010111: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic drive(logic [6:0] op);
    item_t it;
    @(posedge clk);
    opcode = op;
    it.opc = op;
    it.exp = model(op);
    sb.push_back(it);
  endtask

  // Monitor: compares one scoreboard item per falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      exp_t act;
      it  = sb.pop_front();
      act = {reg_wr, mem_rd, mem_wr, op2_sel, wb_sel, is_branch, is_jal,
             is_jalr, alu_class, illegal};
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s/R10 opcode=%b actual=%b expected=%b",
                 tag(it.opc), it.opc, act, it.exp);
      end
      // R9: exclusivity observed at the ports.
      n_tests++;
      if ($countones({is_branch, is_jal, is_jalr}) > 1 || (mem_rd && mem_wr)) begin
        n_fail++;
        $display("FAIL R9 opcode=%b actual=%b%b%b/%b%b expected=exclusive",
                 it.opc, is_branch, is_jal, is_jalr, mem_rd, mem_wr);
      end
    end
  end

  initial begin
    opcode = 7'b0000000;
    // Initial state: opcode 0 is illegal (R8).
    drive(7'b0000000);
    // Each legal group once (R1..R7).
    drive(7'b0010011); drive(7'b0100011); drive(7'b0000011);
    drive(7'b0110011); drive(7'b1100011); drive(7'b1101111);
    drive(7'b1100111); drive(7'b0110111); drive(7'b0010111);
    // R8: all-ones and near misses of legal codes.
    drive(7'b1111111);
    drive(7'b0010010); drive(7'b0100111); drive(7'b1100001);
    drive(7'b1101011); drive(7'b0110110);
    // Legal-to-illegal-to-legal transitions.
    drive(7'b0000011); drive(7'b1111111); drive(7'b0100011);
    // Full sweep ascending then descending.
    for (int i = 0; i < 128; i++) drive(7'(i));
    for (int i = 127; i >= 0; i--) drive(7'(i));
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule